// File: doc/BRIEF.md
# Two-Bank Interrupt Aggregation Controller

This block gathers sixteen peripheral interrupt requests into two 8-bit banks of latched status flags. Each bank has an enable mask and a write-one-to-clear port. Latched and enabled flags are merged into five CPU interrupt lines, grouped by priority level. Some groups take bits from both banks. A built-in interval timer is fed by a clock prescaler and raises the timer flag each time it reaches terminal count.

Software reaches the block through a byte-wide register port. Status reads always show every latched flag, enabled or not, so a latched bus error can be polled with all interrupts masked. Every request input is a one-cycle pulse. Writing a register takes effect at the clock edge on which the write strobe is sampled. Reads are combinational from the address.

Register addresses:

| Address | Register |
|---|---|
| 0 | bank-0 status, read only |
| 1 | bank-1 status, read only |
| 2 | bank-0 enable |
| 3 | bank-1 enable |
| 4 | bank-0 clear, write only, reads 0 |
| 5 | bank-1 clear, write only, reads 0 |
| 6 | timer reload |

Bank-0 bit order, from bit 7 down to bit 0: parity error, abort, bus error, timer, keyboard, mouse, cache fault, cache busy.

Bank-1 bit order, from bit 7 down to bit 0: beep, serial, LAN, DMA, slot 1, slot 3, external 1, external 3.

Top module: `dual_bank_irq_ctrl`

## Requirements
- R1: After reset, both status registers, both enable registers and the timer reload register read 0, and all five CPU lines are low.
- R2: A request pulse on any input bit sets the matching status bit on the next clock edge, whatever the enable bit holds. The status register is at address 0 for bank 0 and at address 1 for bank 1.
- R3: Writing the clear register (address 4 for bank 0, address 5 for bank 1) clears each status bit written as 1. Bits written as 0 keep their value, and writing 0xFF empties the bank.
- R4: When a request pulse and a clear of the same bit fall on the same edge, the bit ends up set.
- R5: irq_lvl2 is high exactly when any of bank-0 bits 4 (timer), 3 (keyboard) or 2 (mouse) is both latched and enabled.
- R6: irq_lvl0 is high exactly when any of bank-1 bits 4..0 (DMA, slot 1, slot 3, external 1, external 3) is both latched and enabled.
- R7: irq_lvl1 is high exactly when any of bank-0 bits 1..0 (cache fault, cache busy) or bank-1 bits 7..5 (beep, serial, LAN) is both latched and enabled.
- R8: irq_buserr follows bank-0 bit 5 and irq_parity follows bank-0 bit 7, each only when latched and enabled. Bank-0 bit 6 (abort) drives no line.
- R9: After reload value N-1 is written at address 6, the prescaler and counter restart. Bank-0 bit 4 is then set N*PRESCALE cycles after the write edge, and again every N*PRESCALE cycles after that.
- R10: A latched timer flag reaches irq_lvl2 only while bank-0 enable bit 4 is set. Setting that bit later raises the line from the write edge on.
- R11: The enable registers (addresses 2 and 3) and the reload register read back the last value written. The clear addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low synchronous reset |
| reg_we | input | 1 | register write strobe |
| reg_addr | input | 3 | register address |
| reg_wdata | input | 8 | write data |
| reg_rdata | output | 8 | read data, combinational from reg_addr |
| src_bank0 | input | 8 | bank-0 request pulses |
| src_bank1 | input | 8 | bank-1 request pulses |
| irq_lvl0 | output | 1 | CPU line 0 (DMA, slots, external) |
| irq_lvl1 | output | 1 | CPU line 1 (cache, beep, serial, LAN) |
| irq_lvl2 | output | 1 | CPU line 2 (timer, keyboard, mouse) |
| irq_buserr | output | 1 | CPU line 4 (bus error) |
| irq_parity | output | 1 | CPU line 5 (parity/memory error) |

## Verification
A request pulse or a register write sampled at a rising edge shows in the status and enable registers right after that edge. The CPU lines are combinational from those registers, so they are due in the same cycle. The bench drives on falling edges and samples at the following falling edge, one register stage later.

A timer reload is counted from its write edge. The flag is due exactly N*PRESCALE edges later, so the bench checks it one cycle before and one cycle after that edge, over two periods. To keep the run short, the bench uses a small prescale value.

// File: rtl/irq_ctrl_pkg.sv
package irq_ctrl_pkg;
  localparam int BANK_W = 8;
  localparam int ADDR_W = 3;

  localparam logic [ADDR_W-1:0] A_STAT0  = 3'd0;
  localparam logic [ADDR_W-1:0] A_STAT1  = 3'd1;
  localparam logic [ADDR_W-1:0] A_EN0    = 3'd2;
  localparam logic [ADDR_W-1:0] A_EN1    = 3'd3;
  localparam logic [ADDR_W-1:0] A_CLR0   = 3'd4;
  localparam logic [ADDR_W-1:0] A_CLR1   = 3'd5;
  localparam logic [ADDR_W-1:0] A_RELOAD = 3'd6;

  localparam int B0_PARITY = 7;
  localparam int B0_BUSERR = 5;
  localparam int B0_TIMER  = 4;

  localparam logic [BANK_W-1:0] L2_MASK0 = 8'h1C;
  localparam logic [BANK_W-1:0] L1_MASK0 = 8'h03;
  localparam logic [BANK_W-1:0] L1_MASK1 = 8'hE0;
  localparam logic [BANK_W-1:0] L0_MASK1 = 8'h1F;

  function automatic logic [BANK_W-1:0] next_status(
      input logic [BANK_W-1:0] cur, input logic [BANK_W-1:0] set,
      input logic [BANK_W-1:0] clr);
    return (cur & ~clr) | set;
  endfunction

  function automatic logic any_pending(
      input logic [BANK_W-1:0] stat, input logic [BANK_W-1:0] en,
      input logic [BANK_W-1:0] grp);
    return |(stat & en & grp);
  endfunction

  function automatic int timer_period(input int reload, input int prescale);
    return (reload + 1) * prescale;
  endfunction
endpackage

// File: rtl/irq_bank.sv
module irq_bank #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_pulse,
  input  logic         clr_we,
  input  logic [W-1:0] clr_mask,
  input  logic         en_we,
  input  logic [W-1:0] en_val,
  output logic [W-1:0] status,
  output logic [W-1:0] enable
);
  logic [W-1:0] clr_eff;
  assign clr_eff = clr_we ? clr_mask : '0;

  for (genvar i = 0; i < W; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (!rst_n) status[i] <= 1'b0;
      else        status[i] <= (status[i] & ~clr_eff[i]) | set_pulse[i];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     enable <= '0;
    else if (en_we) enable <= en_val;
  end
endmodule

// File: rtl/interval_timer.sv
module interval_timer #(
  parameter int PRESCALE = 6144,
  parameter int CNT_W    = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic [CNT_W-1:0] reload,
  output logic             expire
);
  localparam int PRE_W = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(PRESCALE - 1);

  logic [PRE_W-1:0] pre;
  logic [CNT_W-1:0] cnt;
  logic             tick;

  assign tick   = (pre == PRE_LAST);
  assign expire = tick && (cnt == '0) && !load;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pre <= '0;
      cnt <= '0;
    end else if (load) begin
      pre <= '0;
      cnt <= load_val;
    end else begin
      pre <= tick ? '0 : pre + 1'b1;
      if (tick) cnt <= (cnt == '0) ? reload : cnt - 1'b1;
    end
  end
endmodule

// File: rtl/irq_level_map.sv
module irq_level_map
  import irq_ctrl_pkg::*;
(
  input  logic [BANK_W-1:0] stat0,
  input  logic [BANK_W-1:0] en0,
  input  logic [BANK_W-1:0] stat1,
  input  logic [BANK_W-1:0] en1,
  output logic              lvl0,
  output logic              lvl1,
  output logic              lvl2,
  output logic              buserr,
  output logic              parity
);
  assign lvl0   = any_pending(stat1, en1, L0_MASK1);
  assign lvl1   = any_pending(stat0, en0, L1_MASK0) | any_pending(stat1, en1, L1_MASK1);
  assign lvl2   = any_pending(stat0, en0, L2_MASK0);
  assign buserr = stat0[B0_BUSERR] & en0[B0_BUSERR];
  assign parity = stat0[B0_PARITY] & en0[B0_PARITY];
endmodule

// File: rtl/dual_bank_irq_ctrl.sv
module dual_bank_irq_ctrl
  import irq_ctrl_pkg::*;
#(
  parameter int PRESCALE = 6144
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [BANK_W-1:0] reg_wdata,
  output logic [BANK_W-1:0] reg_rdata,
  input  logic [BANK_W-1:0] src_bank0,
  input  logic [BANK_W-1:0] src_bank1,
  output logic              irq_lvl0,
  output logic              irq_lvl1,
  output logic              irq_lvl2,
  output logic              irq_buserr,
  output logic              irq_parity
);
  logic [BANK_W-1:0] stat0, stat1, en0, en1, reload, set0;
  logic clr0_wr, clr1_wr, en0_wr, en1_wr, reload_wr, tmr_expire;

  assign clr0_wr   = reg_we && (reg_addr == A_CLR0);
  assign clr1_wr   = reg_we && (reg_addr == A_CLR1);
  assign en0_wr    = reg_we && (reg_addr == A_EN0);
  assign en1_wr    = reg_we && (reg_addr == A_EN1);
  assign reload_wr = reg_we && (reg_addr == A_RELOAD);

  always_ff @(posedge clk) begin
    if (!rst_n)         reload <= '0;
    else if (reload_wr) reload <= reg_wdata;
  end

  interval_timer #(.PRESCALE(PRESCALE), .CNT_W(BANK_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(reload_wr), .load_val(reg_wdata),
    .reload(reload), .expire(tmr_expire)
  );

  assign set0 = src_bank0 | (BANK_W'(tmr_expire) << B0_TIMER);

  irq_bank #(.W(BANK_W)) u_bank0 (
    .clk(clk), .rst_n(rst_n), .set_pulse(set0), .clr_we(clr0_wr),
    .clr_mask(reg_wdata), .en_we(en0_wr), .en_val(reg_wdata),
    .status(stat0), .enable(en0)
  );

  irq_bank #(.W(BANK_W)) u_bank1 (
    .clk(clk), .rst_n(rst_n), .set_pulse(src_bank1), .clr_we(clr1_wr),
    .clr_mask(reg_wdata), .en_we(en1_wr), .en_val(reg_wdata),
    .status(stat1), .enable(en1)
  );

  irq_level_map u_map (
    .stat0(stat0), .en0(en0), .stat1(stat1), .en1(en1),
    .lvl0(irq_lvl0), .lvl1(irq_lvl1), .lvl2(irq_lvl2),
    .buserr(irq_buserr), .parity(irq_parity)
  );

  always_comb begin
    unique case (reg_addr)
      A_STAT0:  reg_rdata = stat0;
      A_STAT1:  reg_rdata = stat1;
      A_EN0:    reg_rdata = en0;
      A_EN1:    reg_rdata = en1;
      A_RELOAD: reg_rdata = reload;
      default:  reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/dual_bank_irq_ctrl_checker.sv
module dual_bank_irq_ctrl_checker
  import irq_ctrl_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic [BANK_W-1:0] req0,
  input logic [BANK_W-1:0] req1,
  input logic [BANK_W-1:0] stat0,
  input logic [BANK_W-1:0] stat1,
  input logic [BANK_W-1:0] en0,
  input logic              clr0_wr,
  input logic [BANK_W-1:0] wdata,
  input logic              tmr_expire,
  input logic              irq_lvl2,
  input logic              irq_buserr,
  input logic              irq_parity
);
  // R2 and R4: a pulse is never lost, even under a clear of the same bit
  assert_req0_latched_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (req0 != '0) |=> ((stat0 & $past(req0)) == $past(req0)));
  assert_req1_latched_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (req1 != '0) |=> ((stat1 & $past(req1)) == $past(req1)));
  assert_clear_bank0_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (clr0_wr && ((req0 & wdata) == '0) && !(tmr_expire && wdata[B0_TIMER]))
    |=> ((stat0 & $past(wdata)) == '0));
  assert_timer_sets_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
    tmr_expire |=> stat0[B0_TIMER]);
  assert_line2_needs_enable_R10: assert property (@(posedge clk) disable iff (!rst_n)
    irq_lvl2 |-> ((en0 & stat0 & L2_MASK0) != '0));
  assert_buserr_line_R8: assert property (@(posedge clk) disable iff (!rst_n)
    irq_buserr |-> (stat0[B0_BUSERR] && en0[B0_BUSERR]));
  assert_parity_line_R8: assert property (@(posedge clk) disable iff (!rst_n)
    irq_parity |-> (stat0[B0_PARITY] && en0[B0_PARITY]));
endmodule

bind dual_bank_irq_ctrl dual_bank_irq_ctrl_checker u_chk (
  .clk(clk), .rst_n(rst_n), .req0(src_bank0), .req1(src_bank1),
  .stat0(stat0), .stat1(stat1), .en0(en0), .clr0_wr(clr0_wr),
  .wdata(reg_wdata), .tmr_expire(tmr_expire), .irq_lvl2(irq_lvl2),
  .irq_buserr(irq_buserr), .irq_parity(irq_parity)
);

// File: tb/dual_bank_irq_ctrl_test.sv
module dual_bank_irq_ctrl_test;
  localparam int P = 8;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_we = 1'b0;
  logic [2:0] reg_addr = 3'd0;
  logic [7:0] reg_wdata = 8'h00, reg_rdata;
  logic [7:0] src_bank0 = 8'h00, src_bank1 = 8'h00;
  logic irq_lvl0, irq_lvl1, irq_lvl2, irq_buserr, irq_parity;
  int checks = 0, failures = 0;

  always #2 clk = ~clk;

  dual_bank_irq_ctrl #(.PRESCALE(P)) uut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .src_bank0(src_bank0),
    .src_bank1(src_bank1), .irq_lvl0(irq_lvl0), .irq_lvl1(irq_lvl1),
    .irq_lvl2(irq_lvl2), .irq_buserr(irq_buserr), .irq_parity(irq_parity)
  );

  // {req0, req1, en0, en1, stat0 (timer bit masked), stat1, lines {par,berr,l2,l1,l0}}
  localparam logic [52:0] VEC [12] = '{
    {8'h08, 8'h00, 8'h08, 8'h00, 8'h08, 8'h00, 5'b00100},  // R5 keyboard
    {8'h08, 8'h00, 8'h00, 8'h00, 8'h08, 8'h00, 5'b00000},  // R2 latched while masked
    {8'h00, 8'h10, 8'h00, 8'h10, 8'h00, 8'h10, 5'b00001},  // R6 DMA
    {8'h00, 8'h01, 8'h00, 8'h01, 8'h00, 8'h01, 5'b00001},  // R6 external 3
    {8'h02, 8'h00, 8'h02, 8'h00, 8'h02, 8'h00, 5'b00010},  // R7 cache fault
    {8'h00, 8'h80, 8'h00, 8'h80, 8'h00, 8'h80, 5'b00010},  // R7 beep
    {8'h00, 8'h40, 8'h00, 8'h20, 8'h00, 8'h40, 5'b00000},  // R7 serial masked
    {8'h20, 8'h00, 8'h20, 8'h00, 8'h20, 8'h00, 5'b01000},  // R8 bus error
    {8'h80, 8'h00, 8'h80, 8'h00, 8'h80, 8'h00, 5'b10000},  // R8 parity
    {8'h40, 8'h00, 8'h40, 8'h00, 8'h40, 8'h00, 5'b00000},  // R8 abort no line
    {8'h04, 8'h00, 8'hEF, 8'h00, 8'h04, 8'h00, 5'b00100},  // R5 mouse
    {8'hA1, 8'hFF, 8'h00, 8'hFF, 8'hA1, 8'hFF, 5'b00011}   // R6/R7 full bank 1
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    reg_addr = a; #1; d = reg_rdata;
  endtask

  task automatic pulse(input logic [7:0] r0, input logic [7:0] r1);
    src_bank0 = r0; src_bank1 = r1;
    @(negedge clk);
    src_bank0 = 8'h00; src_bank1 = 8'h00;
  endtask

  function automatic logic [7:0] lines();
    return {3'b000, irq_parity, irq_buserr, irq_lvl2, irq_lvl1, irq_lvl0};
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    rd(3'd0, v); check("R1 stat0", v, 8'h00);
    rd(3'd1, v); check("R1 stat1", v, 8'h00);
    rd(3'd2, v); check("R1 en0", v, 8'h00);
    rd(3'd3, v); check("R1 en1", v, 8'h00);
    rd(3'd6, v); check("R1 reload", v, 8'h00);
    check("R1 lines", lines(), 8'h00);

    foreach (VEC[i]) begin
      wr(3'd4, 8'hFF); wr(3'd5, 8'hFF);
      wr(3'd2, VEC[i][36:29]); wr(3'd3, VEC[i][28:21]);
      pulse(VEC[i][52:45], VEC[i][44:37]);
      rd(3'd0, v); check($sformatf("R2 vec%0d stat0", i), v & 8'hEF, VEC[i][20:13]);
      rd(3'd1, v); check($sformatf("R2 vec%0d stat1", i), v, VEC[i][12:5]);
      check($sformatf("R5/R6/R7/R8 vec%0d lines", i), lines(), {3'b000, VEC[i][4:0]});
    end

    // R3 partial, zero and full clear
    wr(3'd2, 8'h00); wr(3'd3, 8'h00);
    wr(3'd4, 8'hFF); wr(3'd5, 8'hFF);
    pulse(8'h2C, 8'h18);
    wr(3'd4, 8'h08);
    rd(3'd0, v); check("R3 partial clear", v & 8'hEF, 8'h24);
    wr(3'd4, 8'h00);
    rd(3'd0, v); check("R3 zero write keeps", v & 8'hEF, 8'h24);
    wr(3'd5, 8'hFF);
    rd(3'd1, v); check("R3 full clear bank1", v, 8'h00);

    // R4 set wins over clear on the same edge
    src_bank0 = 8'h08;
    wr(3'd4, 8'h0C);
    src_bank0 = 8'h00;
    rd(3'd0, v); check("R4 set wins", v & 8'hEF, 8'h28);

    // R11 readback
    wr(3'd2, 8'h5A); rd(3'd2, v); check("R11 en0", v, 8'h5A);
    wr(3'd3, 8'hA5); rd(3'd3, v); check("R11 en1", v, 8'hA5);
    rd(3'd4, v); check("R11 clear addr reads 0", v, 8'h00);
    wr(3'd2, 8'h00); wr(3'd3, 8'h00);

    // R9 timer: reload 2 -> period 3*P from the write edge
    wr(3'd6, 8'd2);
    rd(3'd6, v); check("R11 reload", v, 8'd2);
    wr(3'd4, 8'hFF);
    repeat (3 * P - 2) @(negedge clk);
    rd(3'd0, v); check("R9 before first expiry", v & 8'h10, 8'h00);
    @(negedge clk);
    rd(3'd0, v); check("R9 first expiry", v & 8'h10, 8'h10);
    check("R10 masked timer line", lines(), 8'h00);
    wr(3'd4, 8'h10);
    repeat (3 * P - 2) @(negedge clk);
    rd(3'd0, v); check("R9 before second expiry", v & 8'h10, 8'h00);
    @(negedge clk);
    rd(3'd0, v); check("R9 second expiry", v & 8'h10, 8'h10);
    wr(3'd2, 8'h10);
    check("R10 enabled timer line", lines(), 8'h04);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule